// File: doc/BRIEF.md
# Auxiliary Channel Host Register Unit

This unit is the host-visible register window of one display auxiliary channel. A host writes up to twenty request bytes into five 32-bit data words, then writes the control word with its send bit set. The unit marks itself busy and presents the request bytes and the request length to a link-side engine. That engine is reduced here to a one-cycle reply strobe carrying response bytes, a byte count and an error flag.

When the reply arrives, the unit leaves busy, raises done and overwrites the data words with the response bytes. It also overwrites the size field with the received count. If no reply comes within a selectable number of microsecond ticks, the unit ends the transfer itself and flags a timeout. Status flags are cleared by writing ones. An optional interrupt follows completion. A separate mutex word lets the host claim and release the channel.

Register addresses are word indices. Index 0 is the control word, indices 1 to 5 are data words 0 to 4, and index 6 is the mutex word. Other indices read as zero.

Top module: `aux_chan_regs`

## Requirements
- R1: After reset the control word, every data word and the mutex word read 0, and irq and link_req are 0.
- R2: While idle, a control write with bit 31 set raises busy (bit 31 reads 1) on the next cycle and clears done (bit 30), timeout error (bit 28) and receive error (bit 25). link_req is high exactly while busy, and link_req_len equals control bits 24:20.
- R3: Request byte 4k+j (j = 0..3) is taken from bits 31-8j down to 24-8j of data word k. It appears on link_req_data bits 8i+7:8i for byte index i. Response bytes use the same layouts in the reverse direction. All twenty byte positions are carried, whatever the length.
- R4: A cycle with link_rsp_valid high while busy ends the transfer on the next edge. Busy falls, done rises, bit 25 takes link_rsp_err, bits 24:20 take link_rsp_len, and the data words take the response bytes.
- R5: Control bits 27:26 select the reply limit in us_tick pulses: 0 = 400, 1 = 600, 2 = 800, 3 = 1600. Only cycles with us_tick high count. On the limit-th tick the unit clears busy and sets done and bit 28, leaving bits 24:20 unchanged. A reply in the same cycle takes precedence.
- R6: An idle control write clears each of bits 30, 28 and 25 for which it carries a 1, and leaves the others unchanged.
- R7: While busy, writes to the control word and to the data words have no effect, and a second start is ignored.
- R8: With bit 29 set when a transfer ends, irq rises together with done and stays high until done is cleared. With bit 29 clear, irq stays low.
- R9: In the mutex word, writing bit 31 = 1 sets the request (bit 31), and the grant (bit 30) follows one cycle later. Writing bit 31 = 0 with bit 30 = 0 drops the request but keeps the grant. Writing bit 31 = 0 with bit 30 = 1 clears both.
- R10: An idle control write stores bits 29, 27:26, 24:20, 19:16 and 10:0 for read-back. Bits 15:11 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| us_tick | input | 1 | One-microsecond tick for the reply timer |
| link_req | output | 1 | Request pending toward the link engine |
| link_req_len | output | 5 | Request byte count |
| link_req_data | output | 160 | Request bytes, byte i at bits 8i+7:8i |
| link_rsp_valid | input | 1 | Reply strobe from the link engine |
| link_rsp_err | input | 1 | Reply carried a receive error |
| link_rsp_len | input | 5 | Received byte count |
| link_rsp_data | input | 160 | Reply bytes, byte i at bits 8i+7:8i |
| irq | output | 1 | Completion interrupt |

## Verification
Every request length from 1 to 20 is run with a byte pattern that depends on both position and length. A swapped lane, a shifted word or a wrong length field therefore shows up as a mismatch. Each run pairs the length with a different reply count and alternates the error flag, which separates the written size from the received size.

Ignored writes arrive in the middle of each transfer; any leak changes the frozen request bytes or the configuration read back afterwards. All four timer selections are run to their exact boundary, one tick short and then at the limit. A run with the tick held low shows that idle cycles do not count.

// File: rtl/aux_pkg.sv
`timescale 1ns/1ps
package aux_pkg;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = 5;
    localparam int N_BYTES = N_WORDS * 4;
    localparam int LEN_W   = 5;
    localparam int ADDR_W  = 3;

    localparam int B_SEND  = 31;
    localparam int B_DONE  = 30;
    localparam int B_IEN   = 29;
    localparam int B_TOERR = 28;
    localparam int B_RXERR = 25;

    typedef struct packed {
        logic             int_en;
        logic [1:0]       tmo_sel;
        logic [LEN_W-1:0] size;
        logic [3:0]       prechg;
        logic [10:0]      clkdiv;
    } ctl_cfg_t;

    typedef struct packed {
        logic busy;
        logic done;
        logic tmo_err;
        logic rx_err;
    } ctl_stat_t;

    function automatic ctl_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        ctl_cfg_t c;
        c.int_en  = w[B_IEN];
        c.tmo_sel = w[27:26];
        c.size    = w[24:20];
        c.prechg  = w[19:16];
        c.clkdiv  = w[10:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctl_word(input ctl_cfg_t c, input ctl_stat_t s);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[B_SEND]  = s.busy;
        w[B_DONE]  = s.done;
        w[B_IEN]   = c.int_en;
        w[B_TOERR] = s.tmo_err;
        w[27:26]   = c.tmo_sel;
        w[B_RXERR] = s.rx_err;
        w[24:20]   = c.size;
        w[19:16]   = c.prechg;
        w[10:0]    = c.clkdiv;
        return w;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/aux_ctl_core.sv
`timescale 1ns/1ps
module aux_ctl_core
    import aux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rsp_fire,
    input  logic              rsp_err,
    input  logic [LEN_W-1:0]  rsp_len,
    input  logic              tmo_fire,
    output ctl_cfg_t          cfg,
    output ctl_stat_t         stat,
    output logic              irq
);
    logic unused_bits;
    assign unused_bits = ^wdata[15:11];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            stat <= '0;
            irq  <= 1'b0;
        end else if (stat.busy) begin
            if (rsp_fire) begin
                stat.busy   <= 1'b0;
                stat.done   <= 1'b1;
                stat.rx_err <= rsp_err;
                cfg.size    <= rsp_len;
                irq         <= cfg.int_en;
            end else if (tmo_fire) begin
                stat.busy    <= 1'b0;
                stat.done    <= 1'b1;
                stat.tmo_err <= 1'b1;
                irq          <= cfg.int_en;
            end
        end else if (ctl_we) begin
            cfg <= cfg_from_word(wdata);
            if (wdata[B_SEND]) begin
                stat <= '{busy: 1'b1, done: 1'b0, tmo_err: 1'b0, rx_err: 1'b0};
                irq  <= 1'b0;
            end else begin
                if (wdata[B_DONE]) begin
                    stat.done <= 1'b0;
                    irq       <= 1'b0;
                end
                if (wdata[B_TOERR]) stat.tmo_err <= 1'b0;
                if (wdata[B_RXERR]) stat.rx_err  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/aux_tmo_timer.sv
`timescale 1ns/1ps
module aux_tmo_timer
    import aux_pkg::*;
#(
    parameter int TMO0 = 400,
    parameter int TMO1 = 600,
    parameter int TMO2 = 800,
    parameter int TMO3 = 1600
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       busy,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       fire
);
    localparam int TMAX = max4(TMO0, TMO1, TMO2, TMO3);
    localparam int CW   = $clog2(TMAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        case (sel)
            2'd0:    limit = CW'(TMO0);
            2'd1:    limit = CW'(TMO1);
            2'd2:    limit = CW'(TMO2);
            default: limit = CW'(TMO3);
        endcase
    end

    assign fire = busy && tick && (cnt == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || !busy) cnt <= '0;
        else if (tick)    cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/aux_data_bank.sv
`timescale 1ns/1ps
module aux_data_bank
    import aux_pkg::*;
#(
    parameter int NW = N_WORDS,
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              load,
    input  logic [NW*32-1:0]  rsp_bytes,
    output logic [NW*32-1:0]  words,
    output logic [NW*32-1:0]  req_bytes
);
    logic [NW*32-1:0] rsp_words;

    for (genvar k = 0; k < NW; k++) begin : g_word
        for (genvar j = 0; j < 4; j++) begin : g_lane
            assign req_bytes[8*(4*k+j) +: 8] = words[32*k + 24 - 8*j +: 8];
            assign rsp_words[32*k + 24 - 8*j +: 8] = rsp_bytes[8*(4*k+j) +: 8];
        end

        always_ff @(posedge clk) begin
            if (rst)
                words[32*k +: 32] <= '0;
            else if (load)
                words[32*k +: 32] <= rsp_words[32*k +: 32];
            else if (wr_en && !busy && wr_idx == AW'(k))
                words[32*k +: 32] <= wdata;
        end
    end
endmodule

// File: rtl/aux_mutex.sv
`timescale 1ns/1ps
module aux_mutex (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] wbits,
    output logic       req,
    output logic       grant
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req   <= 1'b0;
            grant <= 1'b0;
        end else if (we && !wbits[1] && wbits[0]) begin
            req   <= 1'b0;
            grant <= 1'b0;
        end else begin
            if (we)  req   <= wbits[1];
            if (req) grant <= 1'b1;
        end
    end
endmodule

// File: rtl/aux_chan_regs.sv
`timescale 1ns/1ps
module aux_chan_regs
    import aux_pkg::*;
#(
    parameter int TMO0 = 400,
    parameter int TMO1 = 600,
    parameter int TMO2 = 800,
    parameter int TMO3 = 1600
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_we,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [WORD_W-1:0]    host_wdata,
    output logic [WORD_W-1:0]    host_rdata,
    input  logic                 us_tick,
    output logic                 link_req,
    output logic [LEN_W-1:0]     link_req_len,
    output logic [N_BYTES*8-1:0] link_req_data,
    input  logic                 link_rsp_valid,
    input  logic                 link_rsp_err,
    input  logic [LEN_W-1:0]     link_rsp_len,
    input  logic [N_BYTES*8-1:0] link_rsp_data,
    output logic                 irq
);
    localparam logic [ADDR_W-1:0] A_CTL   = '0;
    localparam logic [ADDR_W-1:0] A_MUTEX = ADDR_W'(N_WORDS + 1);

    ctl_cfg_t          cfg;
    ctl_stat_t         stat;
    logic              busy_w, done_w, rsp_fire, tmo_fire;
    logic              ctl_we, data_we, mtx_we;
    logic [ADDR_W-1:0] data_idx;
    logic [N_BYTES*8-1:0] words;
    logic              mtx_req, mtx_grant;

    assign busy_w   = stat.busy;
    assign done_w   = stat.done;
    assign rsp_fire = busy_w && link_rsp_valid;
    assign ctl_we   = host_we && host_addr == A_CTL;
    assign mtx_we   = host_we && host_addr == A_MUTEX;
    assign data_we  = host_we && host_addr != A_CTL && host_addr < A_MUTEX;
    assign data_idx = host_addr - ADDR_W'(1);

    aux_ctl_core u_ctl (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .wdata(host_wdata),
        .rsp_fire(rsp_fire), .rsp_err(link_rsp_err), .rsp_len(link_rsp_len),
        .tmo_fire(tmo_fire), .cfg(cfg), .stat(stat), .irq(irq)
    );

    aux_tmo_timer #(.TMO0(TMO0), .TMO1(TMO1), .TMO2(TMO2), .TMO3(TMO3)) u_tmr (
        .clk(clk), .rst(rst), .busy(busy_w), .tick(us_tick),
        .sel(cfg.tmo_sel), .fire(tmo_fire)
    );

    aux_data_bank #(.NW(N_WORDS), .AW(ADDR_W)) u_data (
        .clk(clk), .rst(rst), .busy(busy_w), .wr_en(data_we), .wr_idx(data_idx),
        .wdata(host_wdata), .load(rsp_fire), .rsp_bytes(link_rsp_data),
        .words(words), .req_bytes(link_req_data)
    );

    aux_mutex u_mtx (
        .clk(clk), .rst(rst), .we(mtx_we), .wbits(host_wdata[31:30]),
        .req(mtx_req), .grant(mtx_grant)
    );

    assign link_req     = busy_w;
    assign link_req_len = cfg.size;

    always_comb begin
        host_rdata = '0;
        if (host_addr == A_CTL)   host_rdata = ctl_word(cfg, stat);
        if (host_addr == A_MUTEX) host_rdata = {mtx_req, mtx_grant, 30'b0};
        for (int k = 0; k < N_WORDS; k++)
            if (host_addr == ADDR_W'(k + 1)) host_rdata = words[32*k +: 32];
    end
endmodule

// File: rtl/aux_chan_regs_chk.sv
`timescale 1ns/1ps
module aux_chan_regs_chk
    import aux_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 host_we,
    input logic [ADDR_W-1:0]    host_addr,
    input logic [WORD_W-1:0]    host_wdata,
    input logic                 busy,
    input logic                 done,
    input logic                 irq,
    input logic                 link_rsp_valid,
    input logic [N_BYTES*8-1:0] link_req_data,
    input logic                 grant
);
    a_r2_start_needs_write: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(host_we && host_addr == '0 && host_wdata[B_SEND]));

    a_r2_busy_not_done: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    a_r4_reply_ends: assert property (@(posedge clk) disable iff (rst)
        busy && link_rsp_valid |=> !busy && done);

    a_r7_req_frozen: assert property (@(posedge clk) disable iff (rst)
        busy && !link_rsp_valid |=> $stable(link_req_data));

    a_r8_irq_with_done: assert property (@(posedge clk) disable iff (rst)
        irq |-> done);

    a_r9_grant_release: assert property (@(posedge clk) disable iff (rst)
        $fell(grant) |-> $past(host_we && host_addr == ADDR_W'(N_WORDS + 1)
                               && host_wdata[31:30] == 2'b01));
endmodule

bind aux_chan_regs aux_chan_regs_chk u_chk (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .busy(busy_w), .done(done_w), .irq(irq),
    .link_rsp_valid(link_rsp_valid), .link_req_data(link_req_data),
    .grant(mtx_grant)
);

// File: tb/sim_aux_chan_regs.sv
`timescale 1ns/1ps
module sim_aux_chan_regs;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         host_we = 1'b0;
    logic [2:0]   host_addr = '0;
    logic [31:0]  host_wdata = '0;
    logic [31:0]  host_rdata;
    logic         us_tick = 1'b1;
    logic         link_req;
    logic [4:0]   link_req_len;
    logic [159:0] link_req_data;
    logic         link_rsp_valid = 1'b0;
    logic         link_rsp_err = 1'b0;
    logic [4:0]   link_rsp_len = '0;
    logic [159:0] link_rsp_data = '0;
    logic         irq;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    aux_chan_regs u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .us_tick(us_tick),
        .link_req(link_req), .link_req_len(link_req_len), .link_req_data(link_req_data),
        .link_rsp_valid(link_rsp_valid), .link_rsp_err(link_rsp_err),
        .link_rsp_len(link_rsp_len), .link_rsp_data(link_rsp_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [159:0] got, input logic [159:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic reply(input logic err, input logic [4:0] len, input logic [159:0] data);
        @(negedge clk);
        link_rsp_valid = 1'b1; link_rsp_err = err; link_rsp_len = len; link_rsp_data = data;
        @(negedge clk);
        link_rsp_valid = 1'b0;
    endtask

    function automatic logic [7:0] qb(input int i, input int l);
        return 8'(i * 37 + l * 11 + 1);
    endfunction

    function automatic logic [7:0] pb(input int i, input int l);
        return 8'((i * 53) ^ (l * 29));
    endfunction

    initial begin
        logic [31:0]  v;
        logic [159:0] exp_req, rsp;
        logic [31:0]  w, cw;
        int           lim;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reset word %0d", a), 160'(v), 160'(0));
        end
        chk("R1 irq", 160'(irq), 160'(0));
        chk("R1 link_req", 160'(link_req), 160'(0));

        // R10 config read-back, bits 15:11 dropped
        w = 32'h2000_0000 | (32'd2 << 26) | (32'd7 << 20) | (32'd5 << 16) | 32'h155 | 32'hF800;
        wr(3'd0, w);
        rd(3'd0, v);
        chk("R10 config readback", 160'(v), 160'(w & 32'h2DFF_07FF));
        chk("R10 no irq", 160'(irq), 160'(0));

        // R2 R3 R4 R7 sweep over all lengths
        for (int L = 1; L <= 20; L++) begin
            exp_req = '0;
            rsp = '0;
            for (int i = 0; i < 20; i++) begin
                exp_req[8*i +: 8] = qb(i, L);
                rsp[8*i +: 8] = pb(i, L);
            end
            for (int k = 0; k < 5; k++)
                wr(3'(k + 1), {qb(4*k, L), qb(4*k+1, L), qb(4*k+2, L), qb(4*k+3, L)});
            cw = 32'h8000_0000 | (32'd3 << 26) | (32'(L) << 20) | (32'(L % 16) << 16) | 32'(L * 3);
            wr(3'd0, cw);
            rd(3'd0, v);
            chk($sformatf("R2 busy L=%0d", L), 160'(v[31:30]), 160'(2'b10));
            chk($sformatf("R2 link_req L=%0d", L), 160'(link_req), 160'(1));
            chk($sformatf("R2 req_len L=%0d", L), 160'(link_req_len), 160'(L));
            chk($sformatf("R3 req bytes L=%0d", L), link_req_data, exp_req);
            // R7 writes while busy ignored
            wr(3'd1, 32'hDEAD_BEEF);
            wr(3'd0, 32'h8000_0000 | 32'h2000_0000 | (32'd9 << 20) | 32'h7FF);
            chk($sformatf("R7 req frozen L=%0d", L), link_req_data, exp_req);
            chk($sformatf("R7 len frozen L=%0d", L), 160'(link_req_len), 160'(L));
            reply(1'(L % 2), 5'(21 - L), rsp);
            rd(3'd0, v);
            chk($sformatf("R4 ctl after reply L=%0d", L), 160'(v),
                160'(32'h4000_0000 | (32'(L % 2) << 25) | (32'd3 << 26) | (32'(21 - L) << 20)
                     | (32'(L % 16) << 16) | 32'(L * 3)));
            chk($sformatf("R4 link_req low L=%0d", L), 160'(link_req), 160'(0));
            chk($sformatf("R8 no irq L=%0d", L), 160'(irq), 160'(0));
            for (int k = 0; k < 5; k++) begin
                rd(3'(k + 1), v);
                chk($sformatf("R3 R4 rsp word %0d L=%0d", k, L), 160'(v),
                    160'({pb(4*k, L), pb(4*k+1, L), pb(4*k+2, L), pb(4*k+3, L)}));
            end
        end

        // R6 selective clear: writing zeros keeps done
        wr(3'd0, 32'd3 << 26);
        rd(3'd0, v);
        chk("R6 zeros keep done", 160'(v), 160'(32'h4000_0000 | (32'd3 << 26)));
        wr(3'd0, 32'h4000_0000);
        rd(3'd0, v);
        chk("R6 done cleared", 160'(v), 160'(0));

        // R5 timeout sweep, exact boundary
        for (int s = 0; s < 4; s++) begin
            lim = (s == 0) ? 400 : (s == 1) ? 600 : (s == 2) ? 800 : 1600;
            wr(3'd0, 32'h8000_0000 | (32'(s) << 26) | (32'd2 << 20));
            repeat (lim - 1) @(posedge clk);
            @(negedge clk);
            rd(3'd0, v);
            chk($sformatf("R5 still busy sel=%0d", s), 160'(v[31:28]), 160'(4'b1000));
            @(posedge clk);
            @(negedge clk);
            rd(3'd0, v);
            chk($sformatf("R5 timeout sel=%0d", s), 160'(v),
                160'(32'h4000_0000 | 32'h1000_0000 | (32'(s) << 26) | (32'd2 << 20)));
            wr(3'd0, 32'h1000_0000);
            rd(3'd0, v);
            chk($sformatf("R6 tmo cleared sel=%0d", s), 160'(v), 160'(32'h4000_0000));
            wr(3'd0, 32'h4000_0000);
        end

        // R5 ticks gate the timer
        wr(3'd0, 32'h8000_0000);
        us_tick = 1'b0;
        repeat (500) @(posedge clk);
        @(negedge clk);
        rd(3'd0, v);
        chk("R5 no tick no timeout", 160'(v[31:30]), 160'(2'b10));
        us_tick = 1'b1;
        repeat (400) @(posedge clk);
        @(negedge clk);
        rd(3'd0, v);
        chk("R5 timeout after ticks", 160'(v[31:28]), 160'(4'b0101));
        wr(3'd0, 32'h5000_0000);

        // R8 interrupt
        wr(3'd0, 32'h8000_0000 | 32'h2000_0000 | (32'd3 << 26) | (32'd4 << 20));
        chk("R8 irq low while busy", 160'(irq), 160'(0));
        reply(1'b0, 5'd4, '0);
        chk("R8 irq with done", 160'(irq), 160'(1));
        wr(3'd0, 32'h2000_0000 | (32'd3 << 26));
        chk("R8 irq holds", 160'(irq), 160'(1));
        wr(3'd0, 32'h4000_0000);
        chk("R8 irq cleared", 160'(irq), 160'(0));
        wr(3'd0, 32'h8000_0000 | (32'd1 << 20));
        reply(1'b0, 5'd1, '0);
        rd(3'd0, v);
        chk("R8 done without enable", 160'(v[30]), 160'(1));
        chk("R8 no irq without enable", 160'(irq), 160'(0));

        // R9 mutex
        wr(3'd6, 32'h8000_0000);
        rd(3'd6, v);
        chk("R9 request set", 160'(v), 160'(32'h8000_0000));
        @(posedge clk);
        @(negedge clk);
        rd(3'd6, v);
        chk("R9 granted", 160'(v), 160'(32'hC000_0000));
        wr(3'd6, 32'h0);
        rd(3'd6, v);
        chk("R9 grant kept", 160'(v), 160'(32'h4000_0000));
        wr(3'd6, 32'h4000_0000);
        rd(3'd6, v);
        chk("R9 freed", 160'(v), 160'(0));

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule